// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Blanking Controls

This block turns one 4-bit binary-coded-decimal digit into seven active-high segment drives for a common-cathode display. Digits 0 to 9 light their usual glyphs. The six codes above nine light fixed non-digit shapes, and the highest of them lights nothing.

Three active-low controls sit on top of the plain lookup, in a fixed priority:
- A blanking input darkens the display whatever else is applied.
- A lamp-test input lights every segment.
- A ripple-blanking input darkens the digit only when it is zero. This is how leading or trailing zeros are suppressed.

A ripple-blanking output reports that a zero was suppressed. Chaining that output into the ripple-blanking input of the next digit position carries suppression along a multi-digit display. In a bidirectional-pin design the blanking input and the ripple-blanking output would share one pin; here they are two separate ports.

The outputs pass through an optional register stage chosen by a parameter. The default registers them, so each result appears one clock after its inputs.

Top module: `sevseg_decoder`

## Requirements
- R1: Output bit 0 drives segment a, bit 1 b, bit 2 c, bit 3 d, bit 4 e, bit 5 f and bit 6 g, with 1 meaning lit. With all controls high, digits 0 to 9 give, as hex of bits 6..0: 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F. Digit 6 therefore lights a, and digit 9 lights d.
- R2: With all controls high, codes 10 to 15 give 58, 4C, 62, 69, 78 and 00. Code 15 is fully dark.
- R3: When blank_n is 0, the segment output is 00 for every digit and every setting of the other controls.
- R4: When blank_n is 1 and lamp_test_n is 0, the segment output is 7F for every digit and every setting of rbi_n.
- R5: When blank_n, lamp_test_n and rbi_n are 1, 1 and 0, and the digit is 0, the segment output is 00.
- R6: When rbi_n is 0, lamp_test_n is 1 and blank_n is 1, every nonzero code gives its R1 or R2 pattern.
- R7: rbo_n is 0 exactly when the digit is 0, rbi_n is 0 and lamp_test_n is 1. blank_n has no effect on rbo_n.
- R8: With REG_OUT=1, seg and rbo_n change one clock after their inputs. While rst_n is 0, seg is 00 and rbo_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| digit | input | 4 | BCD digit or code 10..15 |
| lamp_test_n | input | 1 | Lamp test, active low: all segments lit |
| rbi_n | input | 1 | Ripple-blanking input, active low: suppress a zero |
| blank_n | input | 1 | Blanking input, active low: all segments dark |
| seg | output | 7 | Segment drives a..g, active high |
| rbo_n | output | 1 | Ripple-blanking output, active low: a zero was suppressed |

## Verification
With the default register stage, seg and rbo_n are due one rising edge after an input change. The decoder path itself has no further latency.

The bench changes inputs on a falling edge, waits through exactly one rising edge, and samples on the following falling edge. Every sample therefore sees the register loaded from the stimulus under test and nothing later.

The sweep covers all 16 codes against all 8 control combinations, and compares both outputs against values the bench derives from the priority rules. A separate check reads the outputs while reset is held.

// File: rtl/sevseg_pkg.sv
package sevseg_pkg;

   localparam int CODE_W = 4;
   localparam int NSEG   = 7;

   typedef logic [NSEG-1:0] seg_vec_t;

   typedef enum logic [1:0] {
      MODE_GLYPH = 2'd0,
      MODE_DARK  = 2'd1,
      MODE_LAMP  = 2'd2
   } seg_mode_e;

   // Segment shape for a code; bit 0 is segment a, bit 6 is segment g.
   function automatic seg_vec_t code_shape(input logic [CODE_W-1:0] code);
      seg_vec_t s;
      case (code)
         4'd0:    s = 7'h3F;
         4'd1:    s = 7'h06;
         4'd2:    s = 7'h5B;
         4'd3:    s = 7'h4F;
         4'd4:    s = 7'h66;
         4'd5:    s = 7'h6D;
         4'd6:    s = 7'h7D;
         4'd7:    s = 7'h07;
         4'd8:    s = 7'h7F;
         4'd9:    s = 7'h6F;
         4'd10:   s = 7'h58;
         4'd11:   s = 7'h4C;
         4'd12:   s = 7'h62;
         4'd13:   s = 7'h69;
         4'd14:   s = 7'h78;
         default: s = 7'h00;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/sevseg_glyph_rom.sv
module sevseg_glyph_rom
   import sevseg_pkg::*;
#(
   parameter int DIGIT_W = 4,
   parameter int SEG_W   = 7
)(
   input  logic [DIGIT_W-1:0] code,
   output logic [SEG_W-1:0]   shape,
   output logic               code_is_zero
);
   localparam int NCODES = 1 << DIGIT_W;

   generate
      if (DIGIT_W != CODE_W) begin : g_bad_digit_w
         $error("sevseg_glyph_rom: DIGIT_W must be 4");
      end
      if (SEG_W != NSEG) begin : g_bad_seg_w
         $error("sevseg_glyph_rom: SEG_W must be 7");
      end
   endgenerate

   // One-hot code select, then OR of shapes: a decoder feeding a mask OR.
   logic [NCODES-1:0] code_hot;

   generate
      for (genvar i = 0; i < NCODES; i++) begin : g_hot
         assign code_hot[i] = (code == DIGIT_W'(i));
      end
   endgenerate

   always_comb begin
      shape = '0;
      for (int i = 0; i < NCODES; i++) begin
         if (code_hot[i]) shape = shape | code_shape(CODE_W'(i));
      end
   end

   assign code_is_zero = code_hot[0];

endmodule

// File: rtl/sevseg_blank_ctrl.sv
module sevseg_blank_ctrl
   import sevseg_pkg::*;
#(
   parameter int SEG_W = 7
)(
   input  logic             code_is_zero,
   input  logic             lamp_test_n,
   input  logic             rbi_n,
   input  logic             blank_n,
   input  logic [SEG_W-1:0] shape,
   output logic [SEG_W-1:0] seg_next,
   output logic             rbo_next_n
);
   seg_mode_e mode;
   logic      zero_hidden;

   // The zero is suppressed only when lamp test is not active.
   assign zero_hidden = code_is_zero & ~rbi_n & lamp_test_n;

   // Priority: blanking, then lamp test, then zero suppression, then glyph.
   always_comb begin
      if (!blank_n)          mode = MODE_DARK;
      else if (!lamp_test_n) mode = MODE_LAMP;
      else if (zero_hidden)  mode = MODE_DARK;
      else                   mode = MODE_GLYPH;
   end

   generate
      for (genvar b = 0; b < SEG_W; b++) begin : g_seg_mux
         always_comb begin
            case (mode)
               MODE_DARK: seg_next[b] = 1'b0;
               MODE_LAMP: seg_next[b] = 1'b1;
               default:   seg_next[b] = shape[b];
            endcase
         end
      end
   endgenerate

   assign rbo_next_n = ~zero_hidden;

endmodule

// File: rtl/sevseg_out_stage.sv
module sevseg_out_stage #(
   parameter int SEG_W   = 7,
   parameter bit REG_OUT = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEG_W-1:0] seg_d,
   input  logic             rbo_d_n,
   output logic [SEG_W-1:0] seg_q,
   output logic             rbo_q_n
);
   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               seg_q   <= '0;
               rbo_q_n <= 1'b1;
            end else begin
               seg_q   <= seg_d;
               rbo_q_n <= rbo_d_n;
            end
         end

         // R8: outputs carry the previous cycle's decoded values.
         a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (seg_q == $past(seg_d) && rbo_q_n == $past(rbo_d_n)))
            else $error("a_r8_one_cycle");
      end else begin : g_comb
         assign seg_q   = seg_d;
         assign rbo_q_n = rbo_d_n;
      end
   endgenerate

endmodule

// File: rtl/sevseg_decoder.sv
module sevseg_decoder
   import sevseg_pkg::*;
#(
   parameter int DIGIT_W = 4,
   parameter int SEG_W   = 7,
   parameter bit REG_OUT = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DIGIT_W-1:0] digit,
   input  logic               lamp_test_n,
   input  logic               rbi_n,
   input  logic               blank_n,
   output logic [SEG_W-1:0]   seg,
   output logic               rbo_n
);
   localparam logic [SEG_W-1:0] ALL_ON = {SEG_W{1'b1}};

   logic [SEG_W-1:0] shape;
   logic             code_is_zero;
   logic [SEG_W-1:0] seg_next;
   logic             rbo_next_n;

   sevseg_glyph_rom #(.DIGIT_W(DIGIT_W), .SEG_W(SEG_W)) u_rom (
      .code         (digit),
      .shape        (shape),
      .code_is_zero (code_is_zero)
   );

   sevseg_blank_ctrl #(.SEG_W(SEG_W)) u_ctrl (
      .code_is_zero (code_is_zero),
      .lamp_test_n  (lamp_test_n),
      .rbi_n        (rbi_n),
      .blank_n      (blank_n),
      .shape        (shape),
      .seg_next     (seg_next),
      .rbo_next_n   (rbo_next_n)
   );

   sevseg_out_stage #(.SEG_W(SEG_W), .REG_OUT(REG_OUT)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .seg_d   (seg_next),
      .rbo_d_n (rbo_next_n),
      .seg_q   (seg),
      .rbo_q_n (rbo_n)
   );

   // R3: blanking darkens everything.
   a_r3_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
      !blank_n |-> seg_next == '0)
      else $error("a_r3_blank_dark");

   // R4: lamp test lights everything unless blanked.
   a_r4_lamp_lit: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_n && !lamp_test_n) |-> seg_next == ALL_ON)
      else $error("a_r4_lamp_lit");

   // R5: a zero is suppressed under ripple blanking.
   a_r5_zero_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_n && lamp_test_n && !rbi_n && digit == '0) |-> seg_next == '0)
      else $error("a_r5_zero_dark");

   // R6: nonzero codes pass the ROM shape through.
   a_r6_nonzero_shown: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_n && lamp_test_n && digit != '0) |-> seg_next == shape)
      else $error("a_r6_nonzero_shown");

   // R7: ripple output low only for a suppressed zero.
   a_r7_rbo_cause: assert property (@(posedge clk) disable iff (!rst_n)
      !rbo_next_n |-> (digit == '0 && !rbi_n && lamp_test_n))
      else $error("a_r7_rbo_cause");

   a_r7_rbo_lamp_high: assert property (@(posedge clk) disable iff (!rst_n)
      !lamp_test_n |-> rbo_next_n)
      else $error("a_r7_rbo_lamp_high");

endmodule

// File: tb/sevseg_decoder_test.sv
module sevseg_decoder_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] digit = '0;
   logic       lamp_test_n = 1'b1;
   logic       rbi_n = 1'b1;
   logic       blank_n = 1'b1;
   logic [6:0] seg;
   logic       rbo_n;

   int  checks = 0;
   int  failures = 0;
   bit  done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sevseg_decoder uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .digit       (digit),
      .lamp_test_n (lamp_test_n),
      .rbi_n       (rbi_n),
      .blank_n     (blank_n),
      .seg         (seg),
      .rbo_n       (rbo_n)
   );

   // Plain glyph per R1/R2, bit i = segment ('a' + i).
   function automatic logic [6:0] ref_shape(input int code);
      logic [6:0] s;
      case (code)
         0: s = 7'b0111111;   1: s = 7'b0000110;
         2: s = 7'b1011011;   3: s = 7'b1001111;
         4: s = 7'b1100110;   5: s = 7'b1101101;
         6: s = 7'b1111101;   7: s = 7'b0000111;
         8: s = 7'b1111111;   9: s = 7'b1101111;
         10: s = 7'b1011000;  11: s = 7'b1001100;
         12: s = 7'b1100010;  13: s = 7'b1101001;
         14: s = 7'b1111000;  default: s = 7'b0000000;
      endcase
      return s;
   endfunction

   task automatic check_val(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s digit=%0d lt_n=%0b rbi_n=%0b bl_n=%0b got=%h exp=%h",
                  req, digit, lamp_test_n, rbi_n, blank_n, got, exp);
      end
   endtask

   initial begin
      // R8: reset state
      repeat (3) @(negedge clk);
      check_val("R8 reset seg", int'(seg), 0);
      check_val("R8 reset rbo_n", int'(rbo_n), 1);
      rst_n = 1'b1;
      @(negedge clk);

      for (int code = 0; code < 16; code++) begin
         for (int ctl = 0; ctl < 8; ctl++) begin
            logic [6:0] e_seg;
            logic       e_rbo;
            string      tag;
            digit       = 4'(code);
            blank_n     = ctl[2];
            lamp_test_n = ctl[1];
            rbi_n       = ctl[0];
            e_rbo = !(code == 0 && !ctl[0] && ctl[1]);
            if (!ctl[2])                   begin e_seg = 7'h00; tag = "R3"; end
            else if (!ctl[1])              begin e_seg = 7'h7F; tag = "R4"; end
            else if (!ctl[0] && code == 0) begin e_seg = 7'h00; tag = "R5"; end
            else begin
               e_seg = ref_shape(code);
               if (!ctl[0])        tag = "R6";
               else if (code < 10) tag = "R1";
               else                tag = "R2";
            end
            // R8: one rising edge later, sampled on the next falling edge
            @(posedge clk);
            @(negedge clk);
            check_val(tag, int'(seg), int'(e_seg));
            check_val("R7 rbo_n", int'(rbo_n), int'(e_rbo));
         end
      end

      // R8: output holds one cycle after an input change, not earlier
      digit = 4'd8; blank_n = 1'b1; lamp_test_n = 1'b1; rbi_n = 1'b1;
      @(posedge clk); @(negedge clk);
      digit = 4'd1;
      #1;
      check_val("R8 before edge", int'(seg), 'h7F);
      @(posedge clk); @(negedge clk);
      check_val("R8 after edge", int'(seg), 'h06);

      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule